// File: doc/BRIEF.md
# PCI Target Burst Address Sequencer

This block works out the address of every data phase of a memory burst on the target side of a PCI bus. In the address phase it captures the whole 32-bit address word. The two low bits of that word do not give a byte address. They select the burst ordering, and the block keeps them in the stored word so that parity logic elsewhere can use all 32 bits. The dword address the target presents starts at the captured address with the two low bits cleared. It then moves forward on every clock in which the master and the target are both ready.

Two orderings are supported. Linear ordering adds 4 bytes per completed phase and runs across line boundaries. Wrap ordering starts at the critical dword and counts through the 32-byte line, wrapping back to the first dword of the same line, until all eight dwords have moved. Some requests cannot be served: wrap-ordered writes, and either reserved ordering code. For these the block raises a disconnect request once the first data phase has completed. It also raises the request when a wrap burst has delivered all eight dwords and the master still holds FRAME asserted. The bus drivers, parity generation and the memory behind the target are not part of this block.

Top module: `psq_burst_seq`

## Requirements
- R1: After a synchronous reset, busy, disc_req and line_done are 0 and cur_addr is 0.
- R2: An address-phase strobe while idle stores ad_in in addr_word and loads cur_addr with ad_in[31:2] followed by 2'b00. Both are visible, with busy at 1, on the clock after the strobe.
- R3: With ordering code ad_in[1:0] = 2'b00 (linear), each completed data phase adds 4 to cur_addr, including across a 32-byte boundary, and never raises disc_req.
- R4: cur_addr does not change on a clock in which irdy or trdy is 0 (wait state).
- R5: With ordering code 2'b10 (wrap), wrap_mode is 1. Each completed phase adds 1 to cur_addr[4:2] modulo 8 and leaves cur_addr[31:5] unchanged, so offset 0x1C is followed by offset 0x00 of the same line.
- R6: line_done is 1, combinationally, exactly in the cycle in which the eighth data phase of a wrap burst completes. It is 0 in every other cycle.
- R7: If frame is still 1 when the eighth phase of a wrap read completes, disc_req becomes 1 on the next clock.
- R8: A wrap-ordered write (code 2'b10 with cmd_write = 1) raises disc_req on the clock after its first data phase completes, and not before.
- R9: The reserved ordering codes 2'b01 and 2'b11 raise disc_req on the clock after the first data phase completes, for reads and for writes alike.
- R10: A data phase that completes with frame at 0 ends the burst. On the next clock busy and disc_req are 0, and this holds even when the same phase is the eighth phase of a wrap burst.
- R11: An address-phase strobe while busy is ignored: addr_word and cur_addr keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_phase | input | 1 | Address-phase strobe, one clock |
| ad_in | input | 32 | Address word sampled in the address phase |
| cmd_write | input | 1 | 1 when the captured command is a write |
| frame | input | 1 | FRAME asserted (active high) |
| irdy | input | 1 | Master ready (active high) |
| trdy | input | 1 | Target ready (active high) |
| busy | output | 1 | Burst in progress |
| cur_addr | output | 32 | Dword address of the current data phase |
| addr_word | output | 32 | Full captured address word, low bits included |
| wrap_mode | output | 1 | Burst uses wrap ordering |
| line_done | output | 1 | Eighth dword of a wrap line moves this cycle |
| disc_req | output | 1 | Target disconnect requested |

## Verification
Two events can fall in the same clock: the eighth dword of a wrap line completing and the master ending the burst by negating FRAME on that same phase. The bench drives a wrap read whose final completed phase is the eighth one. It checks that line_done is high during that phase and that the next clock shows the block idle with no disconnect request. The contrasting case holds FRAME asserted through the eighth phase and expects the request to appear. A second overlap, an address-phase strobe arriving during a burst, is provoked mid-burst and judged by comparing the stored word and the address before and after.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_RSVD_A = 2'b01,
    ORD_WRAP   = 2'b10,
    ORD_RSVD_B = 2'b11
  } order_t;

  typedef struct packed {
    logic wrap;
    logic early_disc;
  } order_cfg_t;
endpackage

// File: rtl/psq_order_decode.sv
module psq_order_decode
  import psq_pkg::*;
(
  input  logic [1:0]  ord_bits,
  input  logic        is_write,
  output order_cfg_t  cfg
);
  order_t ord;

  always_comb begin
    ord = order_t'(ord_bits);
    cfg = '0;
    case (ord)
      ORD_LINEAR: cfg = '0;
      ORD_WRAP: begin
        cfg.wrap       = 1'b1;
        cfg.early_disc = is_write;
      end
      default: cfg.early_disc = 1'b1;
    endcase
  end
endmodule

// File: rtl/psq_addr_gen.sv
module psq_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              wrap,
  output logic [ADDR_W-1:0] addr,
  output logic              first_beat,
  output logic              line_last
);
  localparam int LINE_DW = LINE_BYTES / 4;
  localparam int OFF_W   = $clog2(LINE_DW);
  localparam int CNT_W   = OFF_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LINE_DW);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_DW - 1);

  logic [CNT_W-1:0] beats;

  function automatic logic [ADDR_W-1:0] dword_align(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] next_linear(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(4);
  endfunction

  function automatic logic [ADDR_W-1:0] next_wrap(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    r[OFF_W+1:2] = a[OFF_W+1:2] + OFF_W'(1);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      beats <= '0;
    end else if (load) begin
      addr  <= dword_align(load_addr);
      beats <= '0;
    end else if (step) begin
      addr  <= wrap ? next_wrap(addr) : next_linear(addr);
      beats <= (beats == CNT_MAX) ? beats : beats + CNT_W'(1);
    end
  end

  assign first_beat = (beats == '0);
  assign line_last  = (beats == CNT_LAST);
endmodule

// File: rtl/psq_phase_ctrl.sv
module psq_phase_ctrl
  import psq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] word_in,
  input  order_cfg_t        cfg_in,
  input  logic              xfer,
  input  logic              burst_end,
  input  logic              first_beat,
  input  logic              line_hit,
  output logic              busy,
  output logic [ADDR_W-1:0] word_q,
  output order_cfg_t        cfg_q,
  output logic              disc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      word_q <= '0;
      cfg_q  <= '0;
      disc_q <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      word_q <= word_in;
      cfg_q  <= cfg_in;
      disc_q <= 1'b0;
    end else if (burst_end) begin
      busy   <= 1'b0;
      disc_q <= 1'b0;
    end else if (xfer && first_beat && cfg_q.early_disc) begin
      disc_q <= 1'b1;
    end else if (line_hit) begin
      disc_q <= 1'b1;
    end
  end
endmodule

// File: rtl/psq_burst_seq.sv
module psq_burst_seq
  import psq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_phase,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic              cmd_write,
  input  logic              frame,
  input  logic              irdy,
  input  logic              trdy,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] addr_word,
  output logic              wrap_mode,
  output logic              line_done,
  output logic              disc_req
);
  order_cfg_t cfg_dec;
  order_cfg_t cfg_q;
  logic start;
  logic xfer;
  logic burst_end;
  logic first_beat;
  logic line_last;

  assign start     = addr_phase && !busy;
  assign xfer      = busy && irdy && trdy;
  assign burst_end = xfer && !frame;
  assign line_done = xfer && cfg_q.wrap && line_last;

  psq_order_decode u_dec (
    .ord_bits (ad_in[1:0]),
    .is_write (cmd_write),
    .cfg      (cfg_dec)
  );

  psq_addr_gen #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_agen (
    .clk        (clk),
    .rst        (rst),
    .load       (start),
    .load_addr  (ad_in),
    .step       (xfer),
    .wrap       (cfg_q.wrap),
    .addr       (cur_addr),
    .first_beat (first_beat),
    .line_last  (line_last)
  );

  psq_phase_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .word_in    (ad_in),
    .cfg_in     (cfg_dec),
    .xfer       (xfer),
    .burst_end  (burst_end),
    .first_beat (first_beat),
    .line_hit   (line_done),
    .busy       (busy),
    .word_q     (addr_word),
    .cfg_q      (cfg_q),
    .disc_q     (disc_req)
  );

  assign wrap_mode = cfg_q.wrap;
endmodule

// File: rtl/psq_burst_seq_chk.sv
module psq_burst_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              xfer,
  input logic              frame,
  input logic              start,
  input logic              wrap_mode,
  input logic              line_done,
  input logic              disc_req,
  input logic [ADDR_W-1:0] cur_addr
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!busy && !disc_req && cur_addr == '0));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (rst)
    (xfer && !wrap_mode) |=> (cur_addr == $past(cur_addr) + ADDR_W'(4)));

  assert_hold_on_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !xfer && !start) |=> $stable(cur_addr));

  assert_wrap_in_line_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer && wrap_mode) |=> (cur_addr[ADDR_W-1:5] == $past(cur_addr[ADDR_W-1:5]) &&
                             cur_addr[4:2] == $past(cur_addr[4:2]) + 3'd1));

  assert_line_done_qual_R6: assert property (@(posedge clk) disable iff (rst)
    line_done |-> (xfer && wrap_mode));

  assert_line_disc_R7: assert property (@(posedge clk) disable iff (rst)
    (line_done && frame) |=> disc_req);

  assert_end_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (xfer && !frame) |=> (!busy && !disc_req));
endmodule

bind psq_burst_seq psq_burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .xfer      (xfer),
  .frame     (frame),
  .start     (start),
  .wrap_mode (wrap_mode),
  .line_done (line_done),
  .disc_req  (disc_req),
  .cur_addr  (cur_addr)
);

// File: tb/sim_psq_burst_seq.sv
`timescale 1ns/100ps
module sim_psq_burst_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        addr_phase;
  logic [31:0] ad_in;
  logic        cmd_write;
  logic        frame;
  logic        irdy;
  logic        trdy;
  logic        busy;
  logic [31:0] cur_addr;
  logic [31:0] addr_word;
  logic        wrap_mode;
  logic        line_done;
  logic        disc_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  psq_burst_seq u0 (
    .clk(clk), .rst(rst), .addr_phase(addr_phase), .ad_in(ad_in),
    .cmd_write(cmd_write), .frame(frame), .irdy(irdy), .trdy(trdy),
    .busy(busy), .cur_addr(cur_addr), .addr_word(addr_word),
    .wrap_mode(wrap_mode), .line_done(line_done), .disc_req(disc_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_bus();
    addr_phase = 0; frame = 0; irdy = 0; trdy = 0; cmd_write = 0; ad_in = 0;
  endtask

  task automatic begin_burst(input logic [31:0] a, input logic wr);
    addr_phase = 1; ad_in = a; cmd_write = wr; frame = 1;
    tick();
    addr_phase = 0; ad_in = 32'hDEAD_BEEF; cmd_write = 0;
    chk("R2 word", addr_word, a);
    chk("R2 addr", cur_addr, {a[31:2], 2'b00});
    chk("R2 busy", 32'(busy), 32'd1);
  endtask

  // one clock with given ready signals; checks combinational line_done first
  task automatic phase(input logic ir, input logic tr, input logic fr, input logic exp_ld);
    irdy = ir; trdy = tr; frame = fr;
    #0.5;
    chk("R6 line_done", 32'(line_done), 32'(exp_ld));
    tick();
    irdy = 0; trdy = 0;
  endtask

  function automatic logic [31:0] wrap_at(input logic [31:0] a, input int i);
    return {a[31:5], 5'b0} + 32'((((a[4:2]) + i) % 8) * 4);
  endfunction

  task automatic t_reset();
    idle_bus();
    rst = 1;
    tick(); tick();
    rst = 0;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 disc", 32'(disc_req), 0);
    chk("R1 addr", cur_addr, 0);
    #0.5 chk("R1 line_done", 32'(line_done), 0);
  endtask

  task automatic t_linear();
    logic [31:0] a = 32'h0000_1018;
    begin_burst(a, 1'b0);
    chk("R3 mode", 32'(wrap_mode), 0);
    phase(1, 1, 1, 0); chk("R3 step", cur_addr, a + 4);
    phase(1, 0, 1, 0); chk("R4 trdy wait", cur_addr, a + 4);
    phase(0, 1, 1, 0); chk("R4 irdy wait", cur_addr, a + 4);
    phase(1, 1, 1, 0); chk("R3 cross line", cur_addr, a + 8);
    addr_phase = 1; ad_in = 32'h0000_7772;
    tick();
    addr_phase = 0;
    chk("R11 word kept", addr_word, a);
    chk("R11 addr kept", cur_addr, a + 8);
    for (int i = 0; i < 6; i++) phase(1, 1, 1, 0);
    chk("R3 long", cur_addr, a + 32);
    chk("R3 no disc", 32'(disc_req), 0);
    phase(1, 1, 0, 0);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 disc", 32'(disc_req), 0);
  endtask

  task automatic t_wrap_read_hold();
    logic [31:0] a = 32'h0000_2016;
    begin_burst(a, 1'b0);
    chk("R5 mode", 32'(wrap_mode), 1);
    for (int i = 1; i <= 8; i++) begin
      phase(1, 1, 1, i == 8);
      chk("R5 wrap addr", cur_addr, wrap_at(a, i));
      if (i < 8) chk("R7 no early disc", 32'(disc_req), 0);
    end
    chk("R7 disc", 32'(disc_req), 1);
    phase(1, 1, 0, 0);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 disc", 32'(disc_req), 0);
  endtask

  task automatic t_wrap_read_end8();
    logic [31:0] a = 32'h0000_40E2;
    begin_burst(a, 1'b0);
    for (int i = 1; i <= 7; i++) begin
      phase(1, 1, 1, 0);
      if (i == 3) phase(0, 0, 1, 0);
    end
    chk("R5 7th", cur_addr, wrap_at(a, 7));
    phase(1, 1, 0, 1);
    chk("R10 end8 busy", 32'(busy), 0);
    chk("R10 end8 disc", 32'(disc_req), 0);
  endtask

  task automatic t_wrap_write();
    logic [31:0] a = 32'h0000_3002;
    begin_burst(a, 1'b1);
    phase(1, 0, 1, 0);
    chk("R8 none before", 32'(disc_req), 0);
    phase(1, 1, 1, 0);
    chk("R8 disc", 32'(disc_req), 1);
    phase(1, 1, 0, 0);
    chk("R10 busy", 32'(busy), 0);
  endtask

  task automatic t_reserved(input logic [1:0] code, input logic wr);
    logic [31:0] a = {30'h0000_1400, code};
    begin_burst(a, wr);
    chk("R9 addr", cur_addr, 32'h0000_5000);
    chk("R9 none before", 32'(disc_req), 0);
    phase(1, 1, 1, 0);
    chk("R9 disc", 32'(disc_req), 1);
    phase(1, 1, 0, 0);
    chk("R10 disc", 32'(disc_req), 0);
  endtask

  task automatic t_linear_write();
    logic [31:0] a = 32'h0000_6010;
    begin_burst(a, 1'b1);
    for (int i = 0; i < 9; i++) phase(1, 1, 1, 0);
    chk("R3 write no disc", 32'(disc_req), 0);
    chk("R3 write addr", cur_addr, a + 36);
    phase(1, 1, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_linear();
    t_wrap_read_hold();
    t_wrap_read_end8();
    t_wrap_write();
    t_reserved(2'b01, 1'b0);
    t_reserved(2'b11, 1'b1);
    t_linear_write();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule